// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block takes a stream of pixels, each with three colour components, and forces every component into a legal code range before the pixel goes on to the output link. A 3-bit format code selects the range. It can be a fixed limited video range for 8-, 10- or 12-bit content, expressed at the block's internal component width. It can instead be a programmable lower and upper bound for each component, or no clamping at all. A separate enable must also be set for any clamping to happen. Two sideband flags, start of frame and end of line, travel with each pixel.

The data path is one register stage with a valid/ready handshake on both sides. A pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. The clamped pixel is presented on the next cycle and stays on the outputs until a cycle with `out_ready` high takes it. Back-pressure reaches the input in the same cycle: `in_ready` drops when the stage holds a pixel and the downstream is not ready. The format and enable inputs are sampled on the edge that accepts a pixel. The programmable bounds are copied into holding registers only while the stage is empty and nothing is offered, so that a change of bounds never lands in the middle of a burst.

Top module: `pix_clamp`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until a pixel is accepted.
- R2: `in_ready` is high exactly when the stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R3: A pixel accepted on edge N appears on the outputs with `out_valid` high after edge N. Its `in_sof` and `in_eol` flags come out unchanged on `out_sof` and `out_eol` in that same cycle.
- R4: When `cfg_en` is 0, or `cfg_fmt` is 0, every component passes through unchanged.
- R5: With `cfg_en`=1 and `cfg_fmt`=1 (8-bit limited), each 12-bit component is clamped to 256..3775. Values below 256 become 256 and values above 3775 become 3775.
- R6: With `cfg_en`=1 and `cfg_fmt`=2 (10-bit limited), each component is clamped to 256..3763.
- R7: With `cfg_en`=1 and `cfg_fmt`=3 (12-bit limited), each component is clamped to 256..3760.
- R8: With `cfg_en`=1 and `cfg_fmt`=7, each component is clamped to its own held lower and upper bounds. The lower test is applied first: a value below the lower bound gives the lower bound, and otherwise a value above the upper bound gives the upper bound. This order also holds when the lower bound exceeds the upper bound.
- R9: After reset the held bounds are 0x010 (lower) and 0xFEF (upper) for all three components. They are reloaded from the six bound inputs on every edge where `in_valid` is 0 and `out_valid` is 0, and they do not change on any other edge.
- R10: With `cfg_en`=1 and `cfg_fmt` of 4, 5 or 6, every component passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Block can take the offered pixel |
| in_r | input | 12 | Red / Cr component in |
| in_g | input | 12 | Green / Y component in |
| in_b | input | 12 | Blue / Cb component in |
| in_sof | input | 1 | Start-of-frame flag in |
| in_eol | input | 1 | End-of-line flag in |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_r | output | 12 | Clamped red component |
| out_g | output | 12 | Clamped green component |
| out_b | output | 12 | Clamped blue component |
| out_sof | output | 1 | Start-of-frame flag out |
| out_eol | output | 1 | End-of-line flag out |
| cfg_en | input | 1 | Clamp enable |
| cfg_fmt | input | 3 | Range code: 0 none, 1/2/3 fixed limited, 7 programmable |
| bnd_lo_r | input | 12 | Programmable lower bound, red |
| bnd_hi_r | input | 12 | Programmable upper bound, red |
| bnd_lo_g | input | 12 | Programmable lower bound, green |
| bnd_hi_g | input | 12 | Programmable upper bound, green |
| bnd_lo_b | input | 12 | Programmable lower bound, blue |
| bnd_hi_b | input | 12 | Programmable upper bound, blue |

## Verification
The reset defaults of the programmable bounds are the hardest state to observe. Any idle cycle copies the bound inputs over them, so they are visible only if a pixel is accepted before the stage ever goes idle. The bench therefore holds `in_valid` high through reset and its release, with the bound inputs set to other values. It streams pixels against the defaults, then drops `in_valid` for an idle gap and checks that the new bounds take effect. It also sweeps every enable and format code over a grid of component values that includes each limit and its neighbours. One of the programmable components is given a lower bound above its upper bound, to exercise the comparison order.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;

  // Number of colour components per pixel.
  localparam int NCOMP = 3;

  // Format codes whose values software and neighbours rely on.
  localparam logic [2:0] FMT_OFF   = 3'd0;
  localparam logic [2:0] FMT_LIM8  = 3'd1;
  localparam logic [2:0] FMT_LIM10 = 3'd2;
  localparam logic [2:0] FMT_LIM12 = 3'd3;
  localparam logic [2:0] FMT_PROG  = 3'd7;

  // Lower limit of a limited range of depth d, placed at width cw with
  // zero padding below.
  function automatic int unsigned lim_lo(int unsigned d, int unsigned cw);
    return (32'd16 << (d - 8)) << (cw - d);
  endfunction

  // Upper limit of a limited range of depth d, placed at width cw with
  // the padding bits set.
  function automatic int unsigned lim_hi(int unsigned d, int unsigned cw);
    return ((32'd235 << (d - 8)) << (cw - d)) | ((32'd1 << (cw - d)) - 1);
  endfunction

endpackage

// File: rtl/clamp_bounds.sv
module clamp_bounds #(
  parameter int CW = 12,
  parameter int NC = 3,
  parameter logic [CW-1:0] DEF_LO = 'h010,
  parameter logic [CW-1:0] DEF_HI = 'hFEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               refresh,
  input  logic [NC-1:0][CW-1:0] lo_in,
  input  logic [NC-1:0][CW-1:0] hi_in,
  output logic [NC-1:0][CW-1:0] lo_q,
  output logic [NC-1:0][CW-1:0] hi_q
);

  for (genvar c = 0; c < NC; c++) begin : g_comp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[c] <= DEF_LO;
        hi_q[c] <= DEF_HI;
      end else if (refresh) begin
        lo_q[c] <= lo_in[c];
        hi_q[c] <= hi_in[c];
      end
    end
  end

  // R9
  bounds_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (lo_q == $past(lo_in)) && (hi_q == $past(hi_in)));

  // R9
  bounds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable(lo_q) && $stable(hi_q));

endmodule

// File: rtl/clamp_range_dec.sv
module clamp_range_dec #(
  parameter int CW = 12,
  parameter int NC = 3
) (
  input  logic                  en,
  input  logic [2:0]            fmt,
  input  logic [NC-1:0][CW-1:0] prog_lo,
  input  logic [NC-1:0][CW-1:0] prog_hi,
  output logic                  active,
  output logic [NC-1:0][CW-1:0] lo,
  output logic [NC-1:0][CW-1:0] hi
);
  import pix_clamp_pkg::*;

  localparam logic [CW-1:0] LO8  = CW'(lim_lo(8,  CW));
  localparam logic [CW-1:0] HI8  = CW'(lim_hi(8,  CW));
  localparam logic [CW-1:0] LO10 = CW'(lim_lo(10, CW));
  localparam logic [CW-1:0] HI10 = CW'(lim_hi(10, CW));
  localparam logic [CW-1:0] LO12 = CW'(lim_lo(12, CW));
  localparam logic [CW-1:0] HI12 = CW'(lim_hi(12, CW));

  always_comb begin
    active = en;
    lo     = prog_lo;
    hi     = prog_hi;
    case (fmt)
      FMT_LIM8: begin
        for (int c = 0; c < NC; c++) begin
          lo[c] = LO8;
          hi[c] = HI8;
        end
      end
      FMT_LIM10: begin
        for (int c = 0; c < NC; c++) begin
          lo[c] = LO10;
          hi[c] = HI10;
        end
      end
      FMT_LIM12: begin
        for (int c = 0; c < NC; c++) begin
          lo[c] = LO12;
          hi[c] = HI12;
        end
      end
      FMT_PROG: ;
      default: active = 1'b0;
    endcase
  end

endmodule

// File: rtl/clamp_comp.sv
module clamp_comp #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] y
);

  logic below, above;

  assign below = x < lo;
  assign above = x > hi;

  always_comb begin
    if (!active)     y = x;
    else if (below)  y = lo;
    else if (above)  y = hi;
    else             y = x;
  end

  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (lo <= hi)) |-> ((y >= lo) && (y <= hi)));

  // R4
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (y == x));

endmodule

// File: rtl/pix_clamp.sv
module pix_clamp #(
  parameter int CW = 12,
  parameter logic [CW-1:0] DEF_LO = 'h010,
  parameter logic [CW-1:0] DEF_HI = 'hFEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b,
  output logic          out_sof,
  output logic          out_eol,
  input  logic          cfg_en,
  input  logic [2:0]    cfg_fmt,
  input  logic [CW-1:0] bnd_lo_r,
  input  logic [CW-1:0] bnd_hi_r,
  input  logic [CW-1:0] bnd_lo_g,
  input  logic [CW-1:0] bnd_hi_g,
  input  logic [CW-1:0] bnd_lo_b,
  input  logic [CW-1:0] bnd_hi_b
);
  import pix_clamp_pkg::*;

  logic [NCOMP-1:0][CW-1:0] pix_in, pix_cl, pix_q;
  logic [NCOMP-1:0][CW-1:0] bnd_lo_in, bnd_hi_in, bnd_lo_q, bnd_hi_q;
  logic [NCOMP-1:0][CW-1:0] rng_lo, rng_hi;
  logic                     rng_active;
  logic                     accept, refresh;
  logic                     vld_q, sof_q, eol_q;

  assign pix_in    = {in_b, in_g, in_r};
  assign bnd_lo_in = {bnd_lo_b, bnd_lo_g, bnd_lo_r};
  assign bnd_hi_in = {bnd_hi_b, bnd_hi_g, bnd_hi_r};

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign refresh  = !in_valid && !vld_q;

  clamp_bounds #(
    .CW(CW), .NC(NCOMP), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
  ) u_bounds (
    .clk     (clk),
    .rst_n   (rst_n),
    .refresh (refresh),
    .lo_in   (bnd_lo_in),
    .hi_in   (bnd_hi_in),
    .lo_q    (bnd_lo_q),
    .hi_q    (bnd_hi_q)
  );

  clamp_range_dec #(.CW(CW), .NC(NCOMP)) u_dec (
    .en      (cfg_en),
    .fmt     (cfg_fmt),
    .prog_lo (bnd_lo_q),
    .prog_hi (bnd_hi_q),
    .active  (rng_active),
    .lo      (rng_lo),
    .hi      (rng_hi)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_cmp
    clamp_comp #(.CW(CW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (rng_active),
      .x      (pix_in[c]),
      .lo     (rng_lo[c]),
      .hi     (rng_hi[c]),
      .y      (pix_cl[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sof_q <= 1'b0;
      eol_q <= 1'b0;
      pix_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      sof_q <= in_sof;
      eol_q <= in_eol;
      pix_q <= pix_cl;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_sof   = sof_q;
  assign out_eol   = eol_q;
  assign out_r     = pix_q[0];
  assign out_g     = pix_q[1];
  assign out_b     = pix_q[2];

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_r) && $stable(out_g)
      && $stable(out_b) && $stable(out_sof) && $stable(out_eol));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid && (out_sof == $past(in_sof))
      && (out_eol == $past(in_eol)));

  // R4
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_en) |=> (out_r == $past(in_r))
      && (out_g == $past(in_g)) && (out_b == $past(in_b)));

endmodule

// File: tb/sim_pix_clamp.sv
module sim_pix_clamp;
  localparam int CW = 12;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n, in_valid, in_ready, in_sof, in_eol;
  logic          out_valid, out_ready, out_sof, out_eol, cfg_en;
  logic [2:0]    cfg_fmt;
  logic [CW-1:0] in_r, in_g, in_b, out_r, out_g, out_b;
  logic [CW-1:0] bnd_lo_r, bnd_hi_r, bnd_lo_g, bnd_hi_g, bnd_lo_b, bnd_hi_b;

  pix_clamp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r), .out_g(out_g),
    .out_b(out_b), .out_sof(out_sof), .out_eol(out_eol), .cfg_en(cfg_en),
    .cfg_fmt(cfg_fmt), .bnd_lo_r(bnd_lo_r), .bnd_hi_r(bnd_hi_r),
    .bnd_lo_g(bnd_lo_g), .bnd_hi_g(bnd_hi_g), .bnd_lo_b(bnd_lo_b),
    .bnd_hi_b(bnd_hi_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int hold_lo [3];
  int hold_hi [3];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] model(int x, int c);
    int lo, hi;
    if (!cfg_en) return CW'(x);
    case (cfg_fmt)
      3'd1: begin lo = 256; hi = 3775; end
      3'd2: begin lo = 256; hi = 3763; end
      3'd3: begin lo = 256; hi = 3760; end
      3'd7: begin lo = hold_lo[c]; hi = hold_hi[c]; end
      default: return CW'(x);
    endcase
    if (x < lo) return CW'(lo);
    if (x > hi) return CW'(hi);
    return CW'(x);
  endfunction

  function automatic string tag_of();
    if (!cfg_en) return "R4";
    case (cfg_fmt)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd7: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Offer one pixel, let it be taken, and check it one cycle later.
  task automatic pix(int r, int g, int b, bit sof, bit eol, string tag);
    logic [CW-1:0] er, eg, eb;
    er = model(r, 0);
    eg = model(g, 1);
    eb = model(b, 2);
    in_r = CW'(r); in_g = CW'(g); in_b = CW'(b);
    in_sof = sof; in_eol = eol; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(tag, {27'd0, out_valid, out_r, out_g, out_b}, {27'd0, 1'b1, er, eg, eb});
    chk("R3", {62'd0, out_sof, out_eol}, {62'd0, sof, eol});
  endtask

  task automatic idle_refresh();
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hold_lo[0] = bnd_lo_r; hold_hi[0] = bnd_hi_r;
    hold_lo[1] = bnd_lo_g; hold_hi[1] = bnd_hi_g;
    hold_lo[2] = bnd_lo_b; hold_hi[2] = bnd_hi_b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int edges [18] = '{0, 15, 16, 17, 255, 256, 257, 3759, 3760, 3761,
                       3763, 3764, 3775, 3776, 4078, 4079, 4080, 4095};
    rst_n = 1'b0; out_ready = 1'b1; in_valid = 1'b1;
    in_r = 12'h005; in_g = 12'hFFF; in_b = 12'h800; in_sof = 1'b0; in_eol = 1'b0;
    cfg_en = 1'b1; cfg_fmt = 3'd7;
    bnd_lo_r = 12'h300; bnd_hi_r = 12'h500;
    bnd_lo_g = 12'h300; bnd_hi_g = 12'h500;
    bnd_lo_b = 12'h300; bnd_hi_b = 12'h500;
    repeat (3) @(negedge clk);
    chk("R1", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) begin hold_lo[c] = 'h010; hold_hi[c] = 'hFEF; end

    // R9: defaults visible while the stage has never been idle.
    pix(12'h005, 12'hFFF, 12'h800, 1'b1, 1'b0, "R9");
    pix(12'h010, 12'hFEF, 12'h00F, 1'b0, 1'b1, "R9");
    pix(12'hFF0, 12'h011, 12'hFEE, 1'b0, 1'b0, "R9");
    idle_refresh();
    chk("R3", {63'd0, out_valid}, 64'd0);
    pix(12'h2FF, 12'h501, 12'h400, 1'b1, 1'b0, "R9");

    // Sweep every enable and format code over a value grid.
    bnd_lo_r = 12'h100; bnd_hi_r = 12'hC00;
    bnd_lo_g = 12'h040; bnd_hi_g = 12'h3FF;
    bnd_lo_b = 12'h800; bnd_hi_b = 12'h7FF;
    for (int en = 0; en < 2; en++) begin
      for (int code = 0; code < 8; code++) begin
        cfg_en = en[0];
        cfg_fmt = code[2:0];
        idle_refresh();
        for (int i = 0; i < 111; i++) begin
          int v = i * 37;
          pix(v, 4095 - v, (v * 7) % 4096, i == 0, (i % 8) == 7, tag_of());
        end
        for (int i = 0; i < 18; i++) begin
          pix(edges[i], edges[17 - i], edges[(i + 5) % 18], 1'b0, i[0], tag_of());
        end
      end
    end

    // R2: back-pressure holds the output and blocks the input.
    cfg_en = 1'b0;
    idle_refresh();
    out_ready = 1'b0;
    in_r = 12'h111; in_g = 12'h222; in_b = 12'h333; in_sof = 1'b1; in_eol = 1'b0;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_r = 12'hAAA; in_g = 12'hBBB; in_b = 12'hCCC; in_sof = 1'b0; in_eol = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R2", {26'd0, out_valid, in_ready, out_sof, out_eol, out_r, out_g, out_b},
          {26'd0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h111, 12'h222, 12'h333});
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    chk("R2", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R2", {27'd0, out_valid, out_sof, out_eol, out_r, out_g, out_b},
        {27'd0, 1'b1, 1'b0, 1'b1, 12'hAAA, 12'hBBB, 12'hCCC});
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule